// File: doc/BRIEF.md
# Autopoll Device Address Selector

This block decides which device a serial peripheral-bus host should query next while it has nothing else to send. It receives the set of devices enrolled for automatic polling as a 16-bit mask and a flag that says a service request was observed during the last exchange. On a request strobe it produces a single "Talk register 0" command byte together with a one-cycle valid pulse. When no device is enrolled, or when the chosen command is the one the bus transceiver is already repeating by itself, the block issues nothing.

The block also records the history it needs to make that choice. Each time the host confirms that a command byte went out on the bus, the block stores it as the most recent command. A Talk command is additionally stored as the most recent Talk command, and a Talk-register-0 command also as the most recent poll command. Polling sticks to one device and only advances, round-robin, when that device is dropped from the mask or another device asks for service while it is being polled.

Top module: `poll_addr_picker`

## Requirements
- R1: Bit n of `dev_mask_i` enrols device address n; bit 0 is ignored, so address 0 is never polled even when that bit is set.
- R2: A request while no address 1 to 15 is enrolled produces no valid pulse.
- R3: The previous poll address (bits 7:4 of the last poll command) is chosen again while it is still enrolled, unless a service request is flagged and the last command sent equals the last poll command.
- R4: When the previous poll address is no longer enrolled, the selection moves to another enrolled address.
- R5: When `srq_seen_i` is high and the last command sent equals the last poll command, the selection moves away from the previous address.
- R6: A move picks the lowest enrolled address above the previous one; if none exists it wraps to the lowest enrolled address overall (which may be the previous one itself).
- R7: The issued command has the address in bits 7:4 and 4'hC in bits 3:0; `poll_cmd_o` is defined only while `poll_valid_o` is high.
- R8: No valid pulse is produced when the chosen command equals the last command sent.
- R9: A confirmed byte always becomes the last command; it becomes the last Talk command only if bits 3:2 are 2'b11, and the last poll command only if additionally bits 3:0 are 4'hC; otherwise those two hold.
- R10: `poll_valid_o` rises in the cycle after `req_i` and lasts one cycle per request; a byte confirmed in the same cycle as a request affects only later selections.
- R11: Synchronous reset clears the last command, last Talk command, last poll command and the valid output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_mask_i | input | 16 | Enrolled device addresses, one bit per address |
| srq_seen_i | input | 1 | A service request was observed in the last exchange |
| req_i | input | 1 | Strobe: compute and present the next poll command |
| sent_i | input | 1 | Strobe: `sent_byte_i` was confirmed on the bus |
| sent_byte_i | input | 8 | Command byte that went out |
| poll_valid_o | output | 1 | One-cycle pulse, a poll command is offered |
| poll_cmd_o | output | 8 | Offered Talk-register-0 command |
| last_cmd_o | output | 8 | Most recent confirmed command |
| last_talk_o | output | 8 | Most recent confirmed Talk command |
| last_poll_o | output | 8 | Most recent confirmed Talk-register-0 command |

## Verification
The assertions watch, on every cycle, that an offered command has the Talk-register-0 form, never names address 0, names an address that was enrolled at request time, differs from the last command sent, and only follows a request; they also watch how each confirmed byte lands in the three history registers. Whether the block stays on or leaves the previous device, and which address it lands on after a move or a wrap, depends on the history accumulated over many cycles, so only the bench's directed and random scenarios, checked against its behavioural model, show the stay, move and wrap choices are right.

// File: rtl/poll_pkg.sv
package poll_pkg;

    localparam int ADDR_W  = 4;
    localparam int OP_W    = 4;
    localparam int CMD_W   = ADDR_W + OP_W;
    localparam int NDEV    = 1 << ADDR_W;

    localparam logic [OP_W-1:0] TALK0_OP  = 4'hC;
    localparam logic [1:0]      TALK_CODE = 2'b11;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CMD_W-1:0]  cmd_t;
    typedef logic [NDEV-1:0]   devmask_t;

    typedef struct packed {
        cmd_t last;
        cmd_t talk;
        cmd_t poll;
    } hist_t;

    typedef struct packed {
        logic  any;
        addr_t addr;
        cmd_t  cmd;
    } sel_t;

    function automatic cmd_t talk0_cmd(input addr_t a);
        return {a, TALK0_OP};
    endfunction

    function automatic logic is_talk(input cmd_t c);
        return c[3:2] == TALK_CODE;
    endfunction

    function automatic logic is_talk0(input cmd_t c);
        return c[OP_W-1:0] == TALK0_OP;
    endfunction

    function automatic addr_t lowest_set(input devmask_t m);
        addr_t r;
        r = '0;
        for (int i = NDEV - 1; i >= 0; i--) begin
            if (m[i]) r = addr_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/cmd_tracker.sv
module cmd_tracker
    import poll_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sent_i,
    input  cmd_t  byte_i,
    output hist_t hist_o
);

    hist_t hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (sent_i) begin
            hist_q.last <= byte_i;
            if (is_talk(byte_i)) begin
                hist_q.talk <= byte_i;
                if (is_talk0(byte_i)) hist_q.poll <= byte_i;
            end
        end
    end

    assign hist_o = hist_q;

    p_last_rec_r9: assert property (@(posedge clk) disable iff (rst)
        sent_i |=> hist_o.last == $past(byte_i));

    p_poll_rec_r9: assert property (@(posedge clk) disable iff (rst)
        (sent_i && byte_i[3:0] == 4'hC) |=> hist_o.poll == $past(byte_i));

    p_nontalk_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (sent_i && byte_i[3:2] != 2'b11) |=> ($stable(hist_o.talk) && $stable(hist_o.poll)));

    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (hist_o.last == '0 && hist_o.talk == '0 && hist_o.poll == '0));

endmodule

// File: rtl/addr_rotator.sv
module addr_rotator
    import poll_pkg::*;
(
    input  devmask_t mask_i,
    input  addr_t    prev_i,
    output addr_t    next_o
);

    devmask_t above;
    devmask_t higher;

    for (genvar g = 0; g < NDEV; g++) begin : g_above
        assign above[g] = (g > int'(prev_i));
    end

    assign higher = mask_i & above;
    assign next_o = (higher != '0) ? lowest_set(higher) : lowest_set(mask_i);

endmodule

// File: rtl/poll_addr_picker.sv
module poll_addr_picker
    import poll_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [15:0] dev_mask_i,
    input  logic       srq_seen_i,
    input  logic       req_i,
    input  logic       sent_i,
    input  logic [7:0] sent_byte_i,
    output logic       poll_valid_o,
    output logic [7:0] poll_cmd_o,
    output logic [7:0] last_cmd_o,
    output logic [7:0] last_talk_o,
    output logic [7:0] last_poll_o
);

    hist_t    hist;
    devmask_t mask_eff;
    addr_t    prev_addr;
    addr_t    next_addr;
    logic     keep_prev;
    sel_t     sel;
    logic     valid_q;
    cmd_t     cmd_q;

    cmd_tracker u_track (
        .clk    (clk),
        .rst    (rst),
        .sent_i (sent_i),
        .byte_i (sent_byte_i),
        .hist_o (hist)
    );

    assign mask_eff  = dev_mask_i & ~devmask_t'(1);
    assign prev_addr = hist.poll[CMD_W-1:OP_W];

    addr_rotator u_rot (
        .mask_i (mask_eff),
        .prev_i (prev_addr),
        .next_o (next_addr)
    );

    always_comb begin
        keep_prev = mask_eff[prev_addr] && !(srq_seen_i && hist.last == hist.poll);
        sel.addr  = keep_prev ? prev_addr : next_addr;
        sel.cmd   = talk0_cmd(sel.addr);
        sel.any   = (mask_eff != '0) && (sel.cmd != hist.last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            cmd_q   <= '0;
        end else begin
            valid_q <= req_i && sel.any;
            if (req_i) cmd_q <= sel.cmd;
        end
    end

    assign poll_valid_o = valid_q;
    assign poll_cmd_o   = cmd_q;
    assign last_cmd_o   = hist.last;
    assign last_talk_o  = hist.talk;
    assign last_poll_o  = hist.poll;

    p_no_addr0_r1: assert property (@(posedge clk) disable iff (rst)
        poll_valid_o |-> poll_cmd_o[7:4] != 4'd0);

    p_empty_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (req_i && dev_mask_i[15:1] == 15'd0) |=> !poll_valid_o);

    p_target_enrolled_r6: assert property (@(posedge clk) disable iff (rst)
        poll_valid_o |-> ((($past(dev_mask_i) >> poll_cmd_o[7:4]) & 16'd1) == 16'd1));

    p_talk0_form_r7: assert property (@(posedge clk) disable iff (rst)
        poll_valid_o |-> poll_cmd_o[3:0] == 4'hC);

    p_no_repeat_r8: assert property (@(posedge clk) disable iff (rst)
        poll_valid_o |-> poll_cmd_o != $past(last_cmd_o));

    p_after_req_r10: assert property (@(posedge clk) disable iff (rst)
        poll_valid_o |-> $past(req_i));

endmodule

// File: tb/poll_addr_picker_bench.sv
module poll_addr_picker_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] dev_mask_i = '0;
    logic        srq_seen_i = 1'b0;
    logic        req_i = 1'b0;
    logic        sent_i = 1'b0;
    logic [7:0]  sent_byte_i = '0;
    logic        poll_valid_o;
    logic [7:0]  poll_cmd_o, last_cmd_o, last_talk_o, last_poll_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_last = 0, m_talk = 0, m_poll = 0;

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    poll_addr_picker u_poll_addr_picker (
        .clk(clk), .rst(rst), .dev_mask_i(dev_mask_i), .srq_seen_i(srq_seen_i),
        .req_i(req_i), .sent_i(sent_i), .sent_byte_i(sent_byte_i),
        .poll_valid_o(poll_valid_o), .poll_cmd_o(poll_cmd_o),
        .last_cmd_o(last_cmd_o), .last_talk_o(last_talk_o), .last_poll_o(last_poll_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one clock: apply inputs at a falling edge, predict, check at the next falling edge
    task automatic step(input bit r, input logic [15:0] m, input bit s, input bit q,
                        input bit sv, input logic [7:0] b, input string tag);
        bit         ev;
        logic [7:0] ec;
        int         pa, a;
        logic [15:0] me;
        bit         keep;
        rst = r; dev_mask_i = m; srq_seen_i = s; req_i = q; sent_i = sv; sent_byte_i = b;
        ev = 0; ec = 0;
        if (r) begin
            m_last = 0; m_talk = 0; m_poll = 0;
        end else begin
            me = m & 16'hFFFE;
            pa = m_poll[7:4];
            keep = me[pa] && !(s && m_last == m_poll);
            a = pa;
            if (!keep) begin
                for (int k = 1; k <= 16; k++) begin
                    if (me[(pa + k) % 16]) begin
                        a = (pa + k) % 16;
                        break;
                    end
                end
            end
            ec = {a[3:0], 4'hC};
            ev = q && (me != 0) && (ec != m_last);
            if (sv) begin
                m_last = b;
                if (b[3:2] == 2'b11) begin
                    m_talk = b;
                    if (b[1:0] == 2'b00) m_poll = b;
                end
            end
        end
        @(negedge clk);
        chk(tag, "valid", int'(poll_valid_o), int'(ev));
        if (ev) chk(tag, "cmd", int'(poll_cmd_o), int'(ec));
        chk(tag, "last_cmd", int'(last_cmd_o), int'(m_last));
        chk(tag, "last_talk", int'(last_talk_o), int'(m_talk));
        chk(tag, "last_poll", int'(last_poll_o), int'(m_poll));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(1, 0, 0, 0, 0, 0, "R11");
        step(1, 0, 0, 0, 0, 0, "R11");
        // R2: nothing enrolled; R1: only bit 0 set
        step(0, 16'h0000, 0, 1, 0, 0, "R2");
        step(0, 16'h0001, 0, 1, 0, 0, "R1");
        // R6/R7: from reset, lowest enrolled address (2) is picked -> 2C
        step(0, 16'h0024, 0, 1, 0, 0, "R7");
        step(0, 16'h0024, 0, 0, 0, 0, "R10");
        step(0, 16'h0024, 0, 0, 1, 8'h2C, "R9");
        // R8: 2C already the last command
        step(0, 16'h0024, 0, 1, 0, 0, "R8");
        // R9: non-Talk byte updates last command only; R3: stay on 2
        step(0, 16'h0024, 0, 0, 1, 8'h31, "R9");
        step(0, 16'h0024, 0, 1, 0, 0, "R3");
        // R3: service request but last command is not the poll command -> stay
        step(0, 16'h0024, 1, 1, 0, 0, "R3");
        // R5: service request while last command is the poll command -> move to 5
        step(0, 16'h0024, 0, 0, 1, 8'h2C, "R9");
        step(0, 16'h0024, 1, 1, 0, 0, "R5");
        // R4/R6: address 2 dropped, enrolled 3 and 5 -> 3
        step(0, 16'h0028, 0, 1, 0, 0, "R4");
        // R6: wrap from 15 to lowest (2)
        step(0, 16'h8004, 0, 0, 1, 8'hFC, "R9");
        step(0, 16'h8004, 1, 1, 0, 0, "R6");
        // R6: only the previous device enrolled, service request -> wraps to itself, suppressed
        step(0, 16'h8000, 1, 1, 0, 0, "R6");
        // R9: Talk register 1 -> talk updated, poll holds
        step(0, 16'h8004, 0, 0, 1, 8'h4D, "R9");
        // R10: request and confirmation in the same cycle
        step(0, 16'h0024, 0, 1, 1, 8'h2C, "R10");
        step(0, 16'h0024, 0, 0, 0, 0, "R10");
        // R11: reset mid-run
        step(1, 16'h0024, 0, 1, 1, 8'h5C, "R11");
        step(0, 16'h0024, 0, 1, 0, 0, "R6");
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0]  rb;
            logic [15:0] rm;
            rb = $urandom();
            if ($urandom() % 2 == 0) rb = {rb[7:4], 4'hC};
            rm = $urandom();
            if ($urandom() % 4 == 0) rm = rm & 16'h0101;
            step(($urandom() % 64) == 0, rm, $urandom() % 2 == 0, $urandom() % 2 == 0,
                 $urandom() % 3 == 0, rb, "R6");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule